// File: doc/BRIEF.md
# Directory-Based Inter-Thread Dependence Tracker

This block records which processors have communicated through shared memory during the current checkpoint interval. Every directory line carries a last-writer tag (a valid flag plus a processor number). Every processor owns two bitmaps. The producer bitmap marks the processors whose data it has consumed. The consumer bitmap marks the processors that have consumed its data. Software reads these bitmaps to work out which processors must checkpoint or roll back as a group.

Coherence events arrive one per cycle as a read or write, a requesting processor and a line index. A write tags the line with its writer. A read of a line tagged by a different processor sets a matched pair of bits: the writer goes into the reader's producer bitmap and the reader goes into the writer's consumer bitmap.

A checkpoint command for processor P clears both of P's bitmaps at once. It then walks the directory one line per cycle and drops the tag on every line whose last writer is P. The block reports busy while this walk runs and accepts no events until it finishes. A lookup port returns the tag of any line, so the directory can be inspected.

Top module: `dep_tracker`

## Requirements
- R1: After reset, busy is low, every bit of both bitmap outputs is 0 and every line reports an invalid tag.
- R2: An accepted write by processor W to line L makes the lookup of L show valid with writer W on the next cycle.
- R3: An accepted read by processor R of a line tagged valid with writer W, where W differs from R, sets bit W of R's producer bitmap and bit R of W's consumer bitmap, visible on the next cycle.
- R4: A read of a line with no valid tag, or of a line last written by the reader itself, leaves both bitmaps unchanged.
- R5: A write to a line already tagged by another processor replaces the tag with the new writer.
- R6: On the cycle after a checkpoint for P is accepted, P's producer and consumer bitmaps are all zero, and every other processor's bitmaps are unchanged.
- R7: After a checkpoint is accepted, busy is high for exactly NLINES cycles starting the next cycle, and ev_ready is low for as long as busy is high.
- R8: When busy falls, every line whose tag named the checkpointed processor is invalid, and all other line tags are unchanged.
- R9: When ckpt_valid is high while the block is idle, the checkpoint is accepted, ev_ready is low and the event offered in that cycle has no effect.
- R10: An event offered while busy is high changes no line tag and no bitmap bit.
- R11: Bitmap outputs are flattened by processor. Bit i*NPROC+j of prod_map is bit j of processor i's producer bitmap, and cons_map uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A coherence event is offered |
| ev_write | input | 1 | 1 = write, 0 = read |
| ev_pid | input | PID_W | Requesting processor |
| ev_line | input | LINE_W | Directory line index |
| ev_ready | output | 1 | The offered event is taken this cycle |
| ckpt_valid | input | 1 | A checkpoint command is offered |
| ckpt_pid | input | PID_W | Processor that checkpoints |
| busy | output | 1 | Directory sweep in progress |
| q_line | input | LINE_W | Line to look up |
| q_valid | output | 1 | Tag valid for q_line |
| q_pid | output | PID_W | Last writer of q_line |
| prod_map | output | NPROC*NPROC | Producer bitmaps, flattened |
| cons_map | output | NPROC*NPROC | Consumer bitmaps, flattened |

## Verification
The hardest situation to reach is an event that arrives while a sweep is running and must be dropped. A second hard case is the same-cycle collision between a checkpoint command and an event. The stimulus reaches the first by holding an event valid for every busy cycle of a sweep. It reaches the second by raising both commands on the same edge. In each case it then reads the touched line through the lookup port and compares both bitmaps against a model that applies only the written rules. The bench also builds dependences in both directions before checkpointing one processor, so that the clearing of one row can be told apart from the other rows.

// File: rtl/dep_pkg.sv
package dep_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    // A read creates a dependence only when the line holds a valid tag
    // naming some processor other than the reader.
    function automatic logic is_foreign(input logic tag_ok,
                                        input int unsigned writer,
                                        input int unsigned reader);
        return tag_ok && (writer != reader);
    endfunction

endpackage

// File: rtl/dep_dir.sv
module dep_dir #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    localparam int PID_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    output logic [PID_W-1:0]  rd_pid,
    input  logic [LINE_W-1:0] q_line,
    output logic              q_valid,
    output logic [PID_W-1:0]  q_pid,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] clr_idx,
    input  logic [PID_W-1:0]  clr_pid
);
    logic             tag_v   [NLINES];
    logic [PID_W-1:0] tag_pid [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_v[g]   <= 1'b0;
                tag_pid[g] <= '0;
            end else if (wr_en && wr_line == LINE_W'(g)) begin
                tag_v[g]   <= 1'b1;
                tag_pid[g] <= wr_pid;
            end else if (clr_en && clr_idx == LINE_W'(g) && tag_pid[g] == clr_pid) begin
                tag_v[g]   <= 1'b0;
            end
        end
    end

    assign rd_valid = tag_v[rd_line];
    assign rd_pid   = tag_pid[rd_line];
    assign q_valid  = tag_v[q_line];
    assign q_pid    = tag_pid[q_line];

endmodule

// File: rtl/dep_maps.sv
module dep_maps #(
    parameter int NPROC = 4,
    localparam int PID_W = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int MAP_W = NPROC * NPROC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [PID_W-1:0] set_reader,
    input  logic [PID_W-1:0] set_writer,
    input  logic             clr_en,
    input  logic [PID_W-1:0] clr_pid,
    output logic [MAP_W-1:0] prod_map,
    output logic [MAP_W-1:0] cons_map
);
    for (genvar i = 0; i < NPROC; i++) begin : g_proc
        logic [NPROC-1:0] prod_row;
        logic [NPROC-1:0] cons_row;

        always_ff @(posedge clk) begin
            if (rst) begin
                prod_row <= '0;
                cons_row <= '0;
            end else if (clr_en && clr_pid == PID_W'(i)) begin
                prod_row <= '0;
                cons_row <= '0;
            end else if (set_en) begin
                if (set_reader == PID_W'(i)) prod_row[set_writer] <= 1'b1;
                if (set_writer == PID_W'(i)) cons_row[set_reader] <= 1'b1;
            end
        end

        assign prod_map[i*NPROC +: NPROC] = prod_row;
        assign cons_map[i*NPROC +: NPROC] = cons_row;
    end

endmodule

// File: rtl/dep_ctrl.sv
module dep_ctrl #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    localparam int PID_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ckpt_valid,
    input  logic [PID_W-1:0]  ckpt_pid,
    output logic              ev_take,
    output logic              ckpt_take,
    output logic              busy,
    output logic              sweep_en,
    output logic [LINE_W-1:0] sweep_idx,
    output logic [PID_W-1:0]  sweep_pid
);
    import dep_pkg::*;

    sweep_state_e state;
    logic         last_idx;

    assign busy      = (state == ST_SWEEP);
    assign ckpt_take = ckpt_valid && !busy;
    assign ev_take   = ev_valid && !busy && !ckpt_valid;
    assign sweep_en  = busy;
    assign last_idx  = (sweep_idx == LINE_W'(NLINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sweep_idx <= '0;
            sweep_pid <= '0;
        end else begin
            case (state)
                ST_IDLE: if (ckpt_take) begin
                    state     <= ST_SWEEP;
                    sweep_idx <= '0;
                    sweep_pid <= ckpt_pid;
                end
                ST_SWEEP: begin
                    if (last_idx) state <= ST_IDLE;
                    else          sweep_idx <= sweep_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dep_tracker.sv
module dep_tracker #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    localparam int PID_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int MAP_W  = NPROC * NPROC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_write,
    input  logic [PID_W-1:0]  ev_pid,
    input  logic [LINE_W-1:0] ev_line,
    output logic              ev_ready,
    input  logic              ckpt_valid,
    input  logic [PID_W-1:0]  ckpt_pid,
    output logic              busy,
    input  logic [LINE_W-1:0] q_line,
    output logic              q_valid,
    output logic [PID_W-1:0]  q_pid,
    output logic [MAP_W-1:0]  prod_map,
    output logic [MAP_W-1:0]  cons_map
);
    logic              ev_take, ckpt_take, sweep_en;
    logic [LINE_W-1:0] sweep_idx;
    logic [PID_W-1:0]  sweep_pid;
    logic              rd_valid;
    logic [PID_W-1:0]  rd_pid;
    logic              dep_set;

    dep_ctrl #(.NPROC(NPROC), .NLINES(NLINES)) u_ctrl (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ckpt_valid(ckpt_valid), .ckpt_pid(ckpt_pid),
        .ev_take(ev_take), .ckpt_take(ckpt_take), .busy(busy),
        .sweep_en(sweep_en), .sweep_idx(sweep_idx), .sweep_pid(sweep_pid)
    );

    dep_dir #(.NPROC(NPROC), .NLINES(NLINES)) u_dir (
        .clk(clk), .rst(rst),
        .wr_en(ev_take && ev_write), .wr_line(ev_line), .wr_pid(ev_pid),
        .rd_line(ev_line), .rd_valid(rd_valid), .rd_pid(rd_pid),
        .q_line(q_line), .q_valid(q_valid), .q_pid(q_pid),
        .clr_en(sweep_en), .clr_idx(sweep_idx), .clr_pid(sweep_pid)
    );

    assign dep_set = ev_take && !ev_write &&
                     dep_pkg::is_foreign(rd_valid, int'(rd_pid), int'(ev_pid));

    dep_maps #(.NPROC(NPROC)) u_maps (
        .clk(clk), .rst(rst),
        .set_en(dep_set), .set_reader(ev_pid), .set_writer(rd_pid),
        .clr_en(ckpt_take), .clr_pid(ckpt_pid),
        .prod_map(prod_map), .cons_map(cons_map)
    );

    assign ev_ready = !busy && !ckpt_valid;

endmodule

// File: rtl/dep_tracker_chk.sv
module dep_tracker_chk #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    localparam int PID_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int MAP_W  = NPROC * NPROC
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             ev_ready,
    input logic             ckpt_valid,
    input logic             ckpt_take,
    input logic [PID_W-1:0] ckpt_pid,
    input logic             dep_set,
    input logic [PID_W-1:0] dep_rd,
    input logic [PID_W-1:0] dep_wr,
    input logic [MAP_W-1:0] prod_map,
    input logic [MAP_W-1:0] cons_map
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    // R7
    busy_blocks_ev_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ev_ready);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_cnt == NLINES);

    // R9
    ckpt_first_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_valid |-> !ev_ready);

    // R3
    dep_pair_chk: assert property (@(posedge clk) disable iff (rst)
        dep_set |=> prod_map[int'($past(dep_rd))*NPROC + int'($past(dep_wr))] &&
                    cons_map[int'($past(dep_wr))*NPROC + int'($past(dep_rd))]);

    // R6
    ckpt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_take |=> prod_map[int'($past(ckpt_pid))*NPROC +: NPROC] == '0 &&
                      cons_map[int'($past(ckpt_pid))*NPROC +: NPROC] == '0);

endmodule

bind dep_tracker dep_tracker_chk #(.NPROC(NPROC), .NLINES(NLINES)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .ev_ready(ev_ready),
    .ckpt_valid(ckpt_valid), .ckpt_take(ckpt_take), .ckpt_pid(ckpt_pid),
    .dep_set(dep_set), .dep_rd(ev_pid), .dep_wr(rd_pid),
    .prod_map(prod_map), .cons_map(cons_map)
);

// File: tb/dep_tracker_bench.sv
`timescale 1ns/1ps
module dep_tracker_bench;
    localparam int NPROC  = 4;
    localparam int NLINES = 16;
    localparam int PID_W  = 2;
    localparam int LINE_W = 4;
    localparam int MAP_W  = NPROC * NPROC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_valid = 1'b0, ev_write = 1'b0;
    logic [PID_W-1:0]  ev_pid = '0;
    logic [LINE_W-1:0] ev_line = '0;
    logic ev_ready;
    logic ckpt_valid = 1'b0;
    logic [PID_W-1:0] ckpt_pid = '0;
    logic busy;
    logic [LINE_W-1:0] q_line = '0;
    logic q_valid;
    logic [PID_W-1:0] q_pid;
    logic [MAP_W-1:0] prod_map, cons_map;

    always #2.5 clk = ~clk;

    dep_tracker #(.NPROC(NPROC), .NLINES(NLINES)) u_dep_tracker (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_write(ev_write), .ev_pid(ev_pid), .ev_line(ev_line),
        .ev_ready(ev_ready), .ckpt_valid(ckpt_valid), .ckpt_pid(ckpt_pid),
        .busy(busy), .q_line(q_line), .q_valid(q_valid), .q_pid(q_pid),
        .prod_map(prod_map), .cons_map(cons_map)
    );

    int checks = 0;
    int failures = 0;

    // reference model
    bit          m_v   [NLINES];
    int unsigned m_pid [NLINES];
    bit [MAP_W-1:0] m_prod, m_cons;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int l = 0; l < NLINES; l++) begin
            q_line = LINE_W'(l);
            #0.1;
            chk({req, " tag valid"}, int'(q_valid), int'(m_v[l]));
            if (m_v[l]) chk({req, " tag pid"}, int'(q_pid), int'(m_pid[l]));
        end
        chk({req, " prod_map"}, int'(prod_map), int'(m_prod));
        chk({req, " cons_map"}, int'(cons_map), int'(m_cons));
    endtask

    task automatic ev(bit wr, int p, int l);
        @(negedge clk);
        ev_valid = 1'b1; ev_write = wr; ev_pid = PID_W'(p); ev_line = LINE_W'(l);
        if (wr) begin
            m_v[l] = 1'b1; m_pid[l] = p;
        end else if (m_v[l] && m_pid[l] != p) begin
            m_prod[p*NPROC + int'(m_pid[l])] = 1'b1;
            m_cons[int'(m_pid[l])*NPROC + p] = 1'b1;
        end
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // checkpoint; optionally offer a colliding event and hold it while busy
    task automatic ckpt(string req, int p, bit noise, int np, int nl);
        int busy_cycles = 0;
        @(negedge clk);
        ckpt_valid = 1'b1; ckpt_pid = PID_W'(p);
        if (noise) begin
            ev_valid = 1'b1; ev_write = 1'b1; ev_pid = PID_W'(np); ev_line = LINE_W'(nl);
        end
        #0.1;
        chk({req, " ev_ready low at accept"}, int'(ev_ready), 0);
        m_prod[p*NPROC +: NPROC] = '0;
        m_cons[p*NPROC +: NPROC] = '0;
        @(negedge clk);
        ckpt_valid = 1'b0;
        chk({req, " R6 rows cleared prod"}, int'(prod_map), int'(m_prod));
        chk({req, " R6 rows cleared cons"}, int'(cons_map), int'(m_cons));
        while (busy && busy_cycles < 4 * NLINES) begin
            busy_cycles++;
            chk("R7 ev_ready low while busy", int'(ev_ready), 0);
            @(negedge clk);
        end
        ev_valid = 1'b0;
        chk("R7 busy length", busy_cycles, NLINES);
        for (int l = 0; l < NLINES; l++) if (m_pid[l] == p) m_v[l] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk_all("R1");
    endtask

    task automatic t_basic();
        ev(1'b1, 1, 3);
        chk_all("R2");
        ev(1'b0, 2, 3);
        chk("R11 prod bit 2*4+1", int'(prod_map[9]), 1);
        chk("R11 cons bit 1*4+2", int'(cons_map[6]), 1);
        chk_all("R3");
    endtask

    task automatic t_no_dep();
        ev(1'b0, 0, 5);
        chk_all("R4 invalid line");
        ev(1'b0, 1, 3);
        chk_all("R4 self read");
    endtask

    task automatic t_overwrite();
        ev(1'b1, 3, 3);
        chk_all("R5");
        ev(1'b0, 0, 3);
        chk_all("R5 R3 new writer");
    endtask

    task automatic t_ckpt();
        ev(1'b1, 1, 7);
        ev(1'b1, 2, 8);
        ckpt("R6", 1, 1'b0, 0, 0);
        chk_all("R8");
    endtask

    task automatic t_busy_ignore();
        ckpt("R10", 3, 1'b1, 0, 9);
        chk_all("R10 R8");
    endtask

    task automatic t_priority();
        ckpt("R9", 0, 1'b1, 2, 10);
        chk_all("R9");
        ev(1'b1, 2, 10);
        chk_all("R9 later write");
    endtask

    initial begin
        for (int l = 0; l < NLINES; l++) begin m_v[l] = 1'b0; m_pid[l] = 0; end
        m_prod = '0; m_cons = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_dep();
        t_overwrite();
        t_ckpt();
        t_busy_ignore();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule